// File: doc/BRIEF.md
# Receive Frame Acceptance Filter

This block sits behind a receive MAC and decides, once per frame, whether the frame is kept or thrown away. The destination address comes in as a stream of bytes, first octet first, while the frame is being received. When the frame has finished, the MAC pulses a frame-end strobe and at the same time presents the total frame length and a CRC-error flag. One cycle later the filter returns a single-cycle result: a keep/drop decision and a status word that describes the frame.

The decision combines three things. The first is the destination class: broadcast, multicast, or physical, with a physical destination either matching the station address or not. The second is a set of configuration enables, one per class, plus an accept-all enable for physical destinations. The third is a pair of length rules for frames with a CRC error, one for the normal minimum frame size and a relaxed one at 8 bytes. Runt and oversized frames are flagged in the status word. Multicast frames are accepted or rejected as a single class.

Top module: `rxf_accept_filter`

## Requirements
- R1: A destination of all ones is broadcast. A destination whose first octet has bit 0 set, and which is not all ones, is multicast. Every other destination is physical. The first serial byte is octet 0. Octet k of `station_addr` sits in bits [8k+7:8k]. The status flags `res_bcast`, `res_mcast` and `res_match` report the class, and `res_match` is set only for a physical destination equal to the station address.
- R2: A frame without error is kept when its class is enabled: broadcast by `cfg_acc_bcast`, multicast by `cfg_acc_mcast`, a matching physical destination by `cfg_acc_match`. With the relevant enable at 0 the frame is dropped.
- R3: `cfg_acc_all` keeps every physical destination, matching or not. It never keeps a broadcast or multicast frame.
- R4: `res_runt` is set when the frame length is below 64 bytes. A runt without error is always dropped.
- R5: `res_long` is set when the frame length exceeds 4096 bytes. An oversized frame is still kept when its class is accepted.
- R6: A frame with a CRC error, in an accepted class, is kept only in two cases. The first is `cfg_acc_err`=1 and a length of at least 64. The second is `cfg_acc_err`=0, `cfg_acc_err8`=1 and a length of at least 8. While `cfg_acc_err` is 1, `cfg_acc_err8` has no effect.
- R7: `res_rok` is set for a kept frame without error. `res_err` is set for a kept frame with a CRC error. `res_keep` is set when either of them is set.
- R8: `res_valid` is high for exactly the one cycle after the `rx_frame_end` cycle. All result outputs are 0 in every other cycle.
- R9: A frame that ends before six address bytes have arrived is dropped with all class flags at 0. Bytes after the sixth are ignored.
- R10: During and after reset, before any frame end, all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte_valid | input | 1 | Destination byte present on `rx_byte` |
| rx_byte | input | 8 | Destination address byte, first octet first |
| rx_frame_end | input | 1 | Frame-end strobe, one cycle |
| rx_frame_len | input | 16 | Total frame length in bytes, valid with frame end |
| rx_crc_err | input | 1 | CRC error on this frame, valid with frame end |
| station_addr | input | 48 | Station address, octet k at bits [8k+7:8k] |
| cfg_acc_bcast | input | 1 | Accept broadcast |
| cfg_acc_mcast | input | 1 | Accept multicast |
| cfg_acc_match | input | 1 | Accept physical destination equal to station |
| cfg_acc_all | input | 1 | Accept any physical destination |
| cfg_acc_err | input | 1 | Accept errored frames of 64 bytes or more |
| cfg_acc_err8 | input | 1 | Accept errored frames of 8 bytes or more |
| res_valid | output | 1 | Result valid, one cycle |
| res_keep | output | 1 | Frame kept |
| res_rok | output | 1 | Kept, no error |
| res_err | output | 1 | Kept, with CRC error |
| res_runt | output | 1 | Length below 64 |
| res_long | output | 1 | Length above 4096 |
| res_bcast | output | 1 | Broadcast destination |
| res_mcast | output | 1 | Multicast destination |
| res_match | output | 1 | Physical destination equals station |

## Verification
The assertions assume that the MAC never presents an address byte in the same cycle as the frame-end strobe, and that the strobe lasts a single cycle. The stimulus keeps to both: every frame puts its address bytes on separate cycles, then raises the strobe alone for one cycle and drops it before the next frame starts. Length and error inputs are assumed stable only in the frame-end cycle. The bench changes them only at that point, while the enables are held over the whole frame.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [1:0] {
        CLS_PHYS  = 2'd0,
        CLS_MCAST = 2'd1,
        CLS_BCAST = 2'd2
    } dst_class_e;

    typedef struct packed {
        logic keep;
        logic rok;
        logic err;
        logic runt;
        logic lng;
        logic bcast;
        logic mcast;
        logic pmatch;
    } rx_status_t;

    typedef struct packed {
        logic valid;
        rx_status_t st;
    } rx_result_t;

endpackage

// File: rtl/rxf_addr_capture.sv
module rxf_addr_capture #(
    parameter int ADDR_BYTES = 6,
    localparam int CNT_W = $clog2(ADDR_BYTES + 1),
    localparam int ADDR_W = 8 * ADDR_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [7:0]        byte_in,
    input  logic              frame_end,
    output logic [ADDR_W-1:0] dest,
    output logic              complete
);

    typedef struct packed {
        logic [ADDR_BYTES-1:0][7:0] oct;
        logic [CNT_W-1:0]           cnt;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (frame_end) begin
            cap_d.cnt = '0;
        end else if (byte_valid && (cap_q.cnt < CNT_W'(ADDR_BYTES))) begin
            for (int i = 0; i < ADDR_BYTES; i++) begin
                if (cap_q.cnt == CNT_W'(i)) begin
                    cap_d.oct[i] = byte_in;
                end
            end
            cap_d.cnt = cap_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign dest     = cap_q.oct;
    assign complete = (cap_q.cnt == CNT_W'(ADDR_BYTES));

    // Byte counter never runs past the address length (R9)
    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q.cnt <= CNT_W'(ADDR_BYTES));

    // Input rule: no address byte in the frame-end cycle (R9)
    assert_no_byte_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> !byte_valid);

endmodule

// File: rtl/rxf_class_decode.sv
module rxf_class_decode
    import rxf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    localparam int ADDR_W = 8 * ADDR_BYTES
) (
    input  logic [ADDR_W-1:0] dest,
    input  logic [ADDR_W-1:0] station,
    output dst_class_e        cls,
    output logic              pmatch
);

    logic all_ones;

    always_comb begin
        all_ones = &dest;
        if (all_ones) begin
            cls = CLS_BCAST;
        end else if (dest[0]) begin
            cls = CLS_MCAST;
        end else begin
            cls = CLS_PHYS;
        end
        pmatch = (cls == CLS_PHYS) && (dest == station);
    end

endmodule

// File: rtl/rxf_accept_decide.sv
module rxf_accept_decide
    import rxf_pkg::*;
#(
    parameter int LEN_W       = 16,
    parameter int MIN_LEN     = 64,
    parameter int MAX_LEN     = 4096,
    parameter int ERR_MIN_LEN = 8
) (
    input  dst_class_e       cls,
    input  logic             pmatch,
    input  logic             complete,
    input  logic [LEN_W-1:0] len,
    input  logic             crc_err,
    input  logic             en_bcast,
    input  logic             en_mcast,
    input  logic             en_match,
    input  logic             en_all,
    input  logic             en_err,
    input  logic             en_err8,
    output rx_status_t       st
);

    logic is_b, is_m, is_p;
    logic addr_ok, len_ok, runt, lng;

    always_comb begin
        is_b = complete && (cls == CLS_BCAST);
        is_m = complete && (cls == CLS_MCAST);
        is_p = complete && (cls == CLS_PHYS);

        addr_ok = (is_b && en_bcast)
               || (is_m && en_mcast)
               || (is_p && pmatch && en_match)
               || (is_p && en_all);

        runt = (len < LEN_W'(MIN_LEN));
        lng  = (len > LEN_W'(MAX_LEN));

        if (!crc_err) begin
            len_ok = !runt;
        end else if (en_err) begin
            len_ok = !runt;
        end else if (en_err8) begin
            len_ok = (len >= LEN_W'(ERR_MIN_LEN));
        end else begin
            len_ok = 1'b0;
        end

        st.keep   = addr_ok && len_ok;
        st.rok    = st.keep && !crc_err;
        st.err    = st.keep && crc_err;
        st.runt   = runt;
        st.lng    = lng;
        st.bcast  = is_b;
        st.mcast  = is_m;
        st.pmatch = is_p && pmatch;
    end

endmodule

// File: rtl/rxf_accept_filter.sv
module rxf_accept_filter
    import rxf_pkg::*;
#(
    parameter int ADDR_BYTES  = 6,
    parameter int LEN_W       = 16,
    parameter int MIN_LEN     = 64,
    parameter int MAX_LEN     = 4096,
    parameter int ERR_MIN_LEN = 8,
    localparam int ADDR_W = 8 * ADDR_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_byte_valid,
    input  logic [7:0]        rx_byte,
    input  logic              rx_frame_end,
    input  logic [LEN_W-1:0]  rx_frame_len,
    input  logic              rx_crc_err,
    input  logic [ADDR_W-1:0] station_addr,
    input  logic              cfg_acc_bcast,
    input  logic              cfg_acc_mcast,
    input  logic              cfg_acc_match,
    input  logic              cfg_acc_all,
    input  logic              cfg_acc_err,
    input  logic              cfg_acc_err8,
    output logic              res_valid,
    output logic              res_keep,
    output logic              res_rok,
    output logic              res_err,
    output logic              res_runt,
    output logic              res_long,
    output logic              res_bcast,
    output logic              res_mcast,
    output logic              res_match
);

    logic [ADDR_W-1:0] dest;
    logic              complete;
    dst_class_e        cls;
    logic              pmatch;
    rx_status_t        dec_st;
    rx_result_t        res_d, res_q;

    rxf_addr_capture #(.ADDR_BYTES(ADDR_BYTES)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (rx_byte_valid),
        .byte_in    (rx_byte),
        .frame_end  (rx_frame_end),
        .dest       (dest),
        .complete   (complete)
    );

    rxf_class_decode #(.ADDR_BYTES(ADDR_BYTES)) u_cls (
        .dest    (dest),
        .station (station_addr),
        .cls     (cls),
        .pmatch  (pmatch)
    );

    rxf_accept_decide #(
        .LEN_W       (LEN_W),
        .MIN_LEN     (MIN_LEN),
        .MAX_LEN     (MAX_LEN),
        .ERR_MIN_LEN (ERR_MIN_LEN)
    ) u_dec (
        .cls      (cls),
        .pmatch   (pmatch),
        .complete (complete),
        .len      (rx_frame_len),
        .crc_err  (rx_crc_err),
        .en_bcast (cfg_acc_bcast),
        .en_mcast (cfg_acc_mcast),
        .en_match (cfg_acc_match),
        .en_all   (cfg_acc_all),
        .en_err   (cfg_acc_err),
        .en_err8  (cfg_acc_err8),
        .st       (dec_st)
    );

    always_comb begin
        res_d = '0;
        if (rx_frame_end) begin
            res_d.valid = 1'b1;
            res_d.st    = dec_st;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid = res_q.valid;
    assign res_keep  = res_q.st.keep;
    assign res_rok   = res_q.st.rok;
    assign res_err   = res_q.st.err;
    assign res_runt  = res_q.st.runt;
    assign res_long  = res_q.st.lng;
    assign res_bcast = res_q.st.bcast;
    assign res_mcast = res_q.st.mcast;
    assign res_match = res_q.st.pmatch;

    // Result appears only the cycle after a frame end (R8)
    assert_valid_after_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(rx_frame_end));

    // Idle cycles carry no result bits (R8)
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !(res_keep || res_runt || res_long || res_bcast || res_mcast || res_match));

    // At most one destination class is reported (R1)
    assert_class_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_bcast, res_mcast, res_match}));

    // Good and errored acceptance are exclusive, keep covers both (R7)
    assert_rok_err_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_rok, res_err}) && (res_keep == (res_rok || res_err)));

    // A runt is never a good accepted frame (R4)
    assert_runt_not_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
        res_runt |-> !res_rok);

    // Oversized and runt are disjoint (R5)
    assert_long_not_runt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_long |-> !res_runt);

    // Frame-end strobe lasts a single cycle (R8)
    assert_end_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_end |=> !rx_frame_end);

endmodule

// File: tb/rxf_accept_filter_tb.sv
module rxf_accept_filter_tb_top;

    typedef struct packed {
        logic [47:0] dst;
        logic [15:0] len;
        logic        crc;
        logic [5:0]  en;   // {all, err8, err, match, mcast, bcast}
        logic [7:0]  exp;  // {keep, rok, err, runt, long, bcast, mcast, match}
    } vec_t;

    localparam logic [47:0] STA = 48'h55_44_33_22_11_02;
    localparam logic [47:0] BRD = 48'hFF_FF_FF_FF_FF_FF;
    localparam logic [47:0] MUL = 48'h00_00_5E_00_00_01;
    localparam logic [47:0] OTH = 48'h55_44_33_22_11_04;
    localparam int NV = 19;

    localparam vec_t VECS [NV] = '{
        '{BRD, 16'd100,  1'b0, 6'b000001, 8'b1100_0100}, // R2 bcast on
        '{BRD, 16'd100,  1'b0, 6'b000000, 8'b0000_0100}, // R2 bcast off
        '{MUL, 16'd200,  1'b0, 6'b000010, 8'b1100_0010}, // R2 mcast on
        '{MUL, 16'd200,  1'b0, 6'b000001, 8'b0000_0010}, // R2 mcast off
        '{STA, 16'd64,   1'b0, 6'b000100, 8'b1100_0001}, // R2 match on, R4 edge
        '{STA, 16'd64,   1'b0, 6'b000000, 8'b0000_0001}, // R2 match off
        '{OTH, 16'd64,   1'b0, 6'b100000, 8'b1100_0000}, // R3 accept all
        '{OTH, 16'd64,   1'b0, 6'b000100, 8'b0000_0000}, // R3 no match
        '{STA, 16'd63,   1'b0, 6'b000100, 8'b0001_0001}, // R4 runt dropped
        '{STA, 16'd5000, 1'b0, 6'b000100, 8'b1100_1001}, // R5 long kept
        '{STA, 16'd4096, 1'b0, 6'b000100, 8'b1100_0001}, // R5 edge not long
        '{STA, 16'd4097, 1'b0, 6'b000100, 8'b1100_1001}, // R5 edge long
        '{STA, 16'd100,  1'b1, 6'b000100, 8'b0000_0001}, // R6 err no enable
        '{STA, 16'd100,  1'b1, 6'b001100, 8'b1010_0001}, // R6 err kept
        '{STA, 16'd63,   1'b1, 6'b001100, 8'b0001_0001}, // R6 err below 64
        '{STA, 16'd63,   1'b1, 6'b010100, 8'b1011_0001}, // R6 err8 keeps
        '{STA, 16'd8,    1'b1, 6'b010100, 8'b1011_0001}, // R6 err8 edge
        '{STA, 16'd7,    1'b1, 6'b010100, 8'b0001_0001}, // R6 below 8
        '{STA, 16'd63,   1'b1, 6'b011100, 8'b0001_0001}  // R6 err overrides err8
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_byte_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_frame_end = 1'b0;
    logic [15:0] rx_frame_len = '0;
    logic        rx_crc_err = 1'b0;
    logic [5:0]  en = '0;
    logic        res_valid, res_keep, res_rok, res_err, res_runt;
    logic        res_long, res_bcast, res_mcast, res_match;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rxf_accept_filter dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_byte_valid (rx_byte_valid),
        .rx_byte       (rx_byte),
        .rx_frame_end  (rx_frame_end),
        .rx_frame_len  (rx_frame_len),
        .rx_crc_err    (rx_crc_err),
        .station_addr  (STA),
        .cfg_acc_bcast (en[0]),
        .cfg_acc_mcast (en[1]),
        .cfg_acc_match (en[2]),
        .cfg_acc_all   (en[5]),
        .cfg_acc_err   (en[3]),
        .cfg_acc_err8  (en[4]),
        .res_valid     (res_valid),
        .res_keep      (res_keep),
        .res_rok       (res_rok),
        .res_err       (res_err),
        .res_runt      (res_runt),
        .res_long      (res_long),
        .res_bcast     (res_bcast),
        .res_mcast     (res_mcast),
        .res_match     (res_match)
    );

    task automatic check(input logic [15:0] got, input logic [15:0] exp, input string tag);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic run_frame(input logic [47:0] dst, input int nbytes, input logic [15:0] len,
                             input logic crc, input logic [5:0] e, input logic [7:0] exp);
        en = e;
        for (int i = 0; i < nbytes; i++) begin
            @(negedge clk);
            rx_byte_valid = 1'b1;
            rx_byte = (i < 6) ? dst[8*i +: 8] : 8'hFF;
        end
        @(negedge clk);
        rx_byte_valid = 1'b0;
        rx_frame_end = 1'b1;
        rx_frame_len = len;
        rx_crc_err = crc;
        @(negedge clk);
        rx_frame_end = 1'b0;
        check(16'(res_valid), 16'd1, "R8 valid after end");
        check(16'({res_bcast, res_mcast, res_match}), 16'(exp[2:0]), "R1 class flags");
        check(16'(res_runt), 16'(exp[4]), "R4 runt flag");
        check(16'(res_long), 16'(exp[3]), "R5 long flag");
        check(16'(res_keep), 16'(exp[7]), "R2 R3 R6 R9 keep");
        check(16'({res_rok, res_err}), 16'(exp[6:5]), "R7 rok/err");
        @(negedge clk);
        check(16'({res_valid, res_keep, res_runt, res_bcast, res_mcast, res_match}), 16'd0,
              "R8 single-cycle result");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(16'({res_valid, res_keep, res_rok, res_err}), 16'd0, "R10 in reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(16'({res_valid, res_keep, res_rok, res_err, res_runt, res_long,
                   res_bcast, res_mcast, res_match}), 16'd0, "R10 after reset");

        for (int v = 0; v < NV; v++) begin
            run_frame(VECS[v].dst, 6, VECS[v].len, VECS[v].crc, VECS[v].en, VECS[v].exp);
        end

        // R9: short address is dropped, class flags clear
        run_frame(STA, 3, 16'd100, 1'b0, 6'b100100, 8'b0000_0000);
        // R9: bytes after the sixth are ignored
        run_frame(STA, 8, 16'd100, 1'b0, 6'b000100, 8'b1100_0001);
        // R3: accept-all never takes multicast
        run_frame(MUL, 6, 16'd100, 1'b0, 6'b100000, 8'b0000_0010);
        // R7: errored broadcast kept
        run_frame(BRD, 6, 16'd100, 1'b1, 6'b001001, 8'b1010_0100);

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule